// File: doc/BRIEF.md
# Serial Configuration Receiver with Rate Switching

This block is the receiving end of a serial configuration load in which the receiver generates the bit clock itself. A fast system clock is divided down to form the configuration clock `cfg_clk`. The upstream serial store presents one data bit per period on `ser_in`, and the block samples that bit on each rising edge of `cfg_clk`. The first `SLOW_BYTES` bytes are always received at a slow, fixed rate. A four-bit rate code sits in byte `RATE_BYTE` of that slow region. Once the slow region has been fully received, the clock switches to the rate that the code selects. The switch happens at a falling edge, so no phase is ever cut short.

The block counts the bits it has taken in. When the count reaches `TOTAL_BITS`, `load_done` rises and internal capture stops. The clock keeps running after that point. Each later bit is passed on to `ser_out` so that the next device in a daisy chain can load. The mode pins decide whether the block runs at all: it runs only when the two low mode bits are both zero, and the top mode bit is ignored.

Top module: `scfg_rx`

## Requirements
- R1: The block runs only when `cfg_mode[1:0]` is `2'b00`, whatever `cfg_mode[2]` holds. While any other value is applied, `cfg_clk`, `ser_out` and `load_done` all hold their values.
- R2: While reset is applied, `cfg_clk`, `ser_out`, `load_done` and `rate_sel` are all 0. After reset, the clock starts in the slow rate.
- R3: Every phase (high and low) of `cfg_clk` lasts `SLOW_HALF` system cycles, from reset until the falling edge that follows the rising edge sampling bit number `SLOW_BYTES*8-1`. Bits are counted from 0.
- R4: `ser_in` is sampled on each rising edge of `cfg_clk`, most significant bit of each byte first. Bits 3..0 of byte `RATE_BYTE` make up the rate code. The code appears on `rate_sel` at the rising edge that samples the last bit of that byte. Before that edge `rate_sel` reads 0.
- R5: After the switch, every phase of `cfg_clk` lasts ceil(`DEF_HALF`/(code+1)) system cycles. Code 0 therefore gives the default rate of `DEF_HALF` cycles per phase.
- R6: The rate changes only at a falling edge of `cfg_clk`. The high phase that follows the last slow bit still lasts `SLOW_HALF` cycles.
- R7: `load_done` rises at the rising edge that samples bit number `TOTAL_BITS-1`, and it stays high until reset.
- R8: `ser_out` is 0 while `load_done` is low. Once `load_done` is high, every rising edge of `cfg_clk` copies `ser_in` onto `ser_out` at that same edge.
- R9: After `load_done` has risen, further data has no effect on `rate_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system clock; the configuration clock is divided from it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 3 | Mode pins; the block runs when bits 1:0 are zero |
| ser_in | input | 1 | Serial configuration data from the upstream store |
| cfg_clk | output | 1 | Generated configuration clock |
| ser_out | output | 1 | Daisy-chain data for the next device |
| load_done | output | 1 | High once the full bitstream length has been received |
| rate_sel | output | 4 | Captured rate code |

## Verification
The bench sweeps all sixteen rate codes and times every phase of `cfg_clk`. A design that switched at the wrong edge, or one bit too early or too late, would produce a clipped or stretched phase around the last slow bit. The bench also checks the exact bit at which the rate code appears and at which `load_done` rises. An off-by-one in either would show a wrong code, or a forwarded bit that is out of step with the stream. A separate sweep over all eight mode values confirms that the top mode bit is ignored and that the block freezes mid-stream when it is disabled.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int RATE_W     = 4;
  localparam int RATE_CODES = 1 << RATE_W;

  // Phase length for a rate code: ceil(def_half / (code + 1)); code 0 keeps the default.
  function automatic int half_for_code(input int def_half, input int code);
    return (def_half + code) / (code + 1);
  endfunction
endpackage

// File: rtl/scfg_clkgen.sv
module scfg_clkgen #(
  parameter int HW        = 5,
  parameter int SLOW_HALF = 20
) (
  input  logic          clk_sys,
  input  logic          rst_sn,
  input  logic          run_en,
  input  logic          fast_ok,
  input  logic [HW-1:0] fast_half,
  output logic          cfg_clk,
  output logic          rise_stb
);
  logic [HW-1:0] cnt_q, cnt_d, half_q, half_d;
  logic          clk_q, clk_d, term;

  always_comb begin
    term     = run_en && (cnt_q == half_q - HW'(1));
    cnt_d    = cnt_q;
    clk_d    = clk_q;
    half_d   = half_q;
    if (run_en) cnt_d = term ? '0 : cnt_q + HW'(1);
    if (term) begin
      clk_d = ~clk_q;
      // a new phase length is taken only as the clock falls
      if (clk_q) half_d = fast_ok ? fast_half : HW'(SLOW_HALF);
    end
    rise_stb = term && !clk_q;
  end

  always_ff @(posedge clk_sys or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      half_q <= HW'(SLOW_HALF);
    end else begin
      cnt_q  <= cnt_d;
      clk_q  <= clk_d;
      half_q <= half_d;
    end
  end

  assign cfg_clk = clk_q;
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
  parameter int CNT_W      = 14,
  parameter int TOTAL_BITS = 8192,
  parameter int SLOW_BITS  = 480,
  parameter int RATE_LAST  = 71
) (
  input  logic                        clk_sys,
  input  logic                        rst_sn,
  input  logic                        rise_stb,
  input  logic                        ser_in,
  output logic                        load_done,
  output logic                        fast_ok,
  output logic [scfg_pkg::RATE_W-1:0] rate_sel
);
  logic [CNT_W-1:0]            cnt_q, cnt_d;
  logic [2:0]                  tail_q, tail_d;
  logic [scfg_pkg::RATE_W-1:0] code_q, code_d;
  logic                        take;

  always_comb begin
    load_done = (cnt_q == CNT_W'(TOTAL_BITS));
    fast_ok   = (cnt_q >= CNT_W'(SLOW_BITS));
    take      = rise_stb && !load_done;
    cnt_d     = take ? cnt_q + CNT_W'(1) : cnt_q;
    tail_d    = take ? {tail_q[1:0], ser_in} : tail_q;
    code_d    = (take && cnt_q == CNT_W'(RATE_LAST)) ? {tail_q, ser_in} : code_q;
  end

  always_ff @(posedge clk_sys or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q  <= '0;
      tail_q <= '0;
      code_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      tail_q <= tail_d;
      code_q <= code_d;
    end
  end

  assign rate_sel = code_q;
endmodule

// File: rtl/scfg_chain_out.sv
module scfg_chain_out (
  input  logic clk_sys,
  input  logic rst_sn,
  input  logic rise_stb,
  input  logic load_done,
  input  logic ser_in,
  output logic ser_out
);
  logic out_q, out_d;

  always_comb out_d = (rise_stb && load_done) ? ser_in : out_q;

  always_ff @(posedge clk_sys or negedge rst_sn) begin
    if (!rst_sn) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign ser_out = out_q;
endmodule

// File: rtl/scfg_rx.sv
module scfg_rx #(
  parameter int SLOW_HALF  = 20,
  parameter int DEF_HALF   = 12,
  parameter int SLOW_BYTES = 60,
  parameter int RATE_BYTE  = 8,
  parameter int TOTAL_BITS = 8192
) (
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic [2:0] cfg_mode,
  input  logic       ser_in,
  output logic       cfg_clk,
  output logic       ser_out,
  output logic       load_done,
  output logic [3:0] rate_sel
);
  import scfg_pkg::*;

  localparam int MAX_HALF  = (SLOW_HALF > DEF_HALF) ? SLOW_HALF : DEF_HALF;
  localparam int HW        = $clog2(MAX_HALF + 1);
  localparam int CNT_W     = $clog2(TOTAL_BITS + 1);
  localparam int SLOW_BITS = SLOW_BYTES * 8;
  localparam int RATE_LAST = RATE_BYTE * 8 + 7;

  logic [1:0]    rst_pipe_q;
  logic          rst_sn, run_en, rise_stb, fast_ok;
  logic [HW-1:0] fast_half;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // top mode bit is a don't-care
  assign run_en = ((cfg_mode & 3'b011) == 3'b000);

  // rate code to phase-length table, folded from the package formula
  always_comb begin
    fast_half = HW'(DEF_HALF);
    for (int c = 0; c < RATE_CODES; c++)
      if (rate_sel == RATE_W'(c)) fast_half = HW'(half_for_code(DEF_HALF, c));
  end

  scfg_clkgen #(.HW(HW), .SLOW_HALF(SLOW_HALF)) u_clkgen (
    .clk_sys  (clk_sys),
    .rst_sn   (rst_sn),
    .run_en   (run_en),
    .fast_ok  (fast_ok),
    .fast_half(fast_half),
    .cfg_clk  (cfg_clk),
    .rise_stb (rise_stb)
  );

  scfg_shifter #(
    .CNT_W(CNT_W), .TOTAL_BITS(TOTAL_BITS),
    .SLOW_BITS(SLOW_BITS), .RATE_LAST(RATE_LAST)
  ) u_shifter (
    .clk_sys  (clk_sys),
    .rst_sn   (rst_sn),
    .rise_stb (rise_stb),
    .ser_in   (ser_in),
    .load_done(load_done),
    .fast_ok  (fast_ok),
    .rate_sel (rate_sel)
  );

  scfg_chain_out u_chain (
    .clk_sys  (clk_sys),
    .rst_sn   (rst_sn),
    .rise_stb (rise_stb),
    .load_done(load_done),
    .ser_in   (ser_in),
    .ser_out  (ser_out)
  );
endmodule

// File: rtl/scfg_rx_chk.sv
module scfg_rx_chk (
  input logic       clk_sys,
  input logic       rst_n,
  input logic [2:0] cfg_mode,
  input logic       cfg_clk,
  input logic       ser_out,
  input logic       load_done,
  input logic [3:0] rate_sel
);
  p_hold_when_off_r1: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (cfg_mode[1:0] != 2'b00) |=> ($stable(cfg_clk) && $stable(load_done) && $stable(ser_out)));

  p_done_sticky_r7: assert property (@(posedge clk_sys) disable iff (!rst_n)
    load_done |=> load_done);

  p_out_quiet_r8: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !load_done |-> !ser_out);

  p_out_on_rise_r8: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !$stable(ser_out) |-> $rose(cfg_clk));

  p_code_frozen_r9: assert property (@(posedge clk_sys) disable iff (!rst_n)
    load_done |=> $stable(rate_sel));
endmodule

bind scfg_rx scfg_rx_chk u_chk (
  .clk_sys  (clk_sys),
  .rst_n    (rst_n),
  .cfg_mode (cfg_mode),
  .cfg_clk  (cfg_clk),
  .ser_out  (ser_out),
  .load_done(load_done),
  .rate_sel (rate_sel)
);

// File: tb/scfg_rx_tb_top.sv
`timescale 1ns/1ps
module scfg_rx_tb_top;
  localparam int SH = 5, DH = 4, SB = 2, RB = 1, TB = 32;
  localparam int NB = TB + 16;

  logic       clk_sys = 1'b0;
  logic       rst_n;
  logic [2:0] cfg_mode;
  logic       ser_in;
  logic       cfg_clk, ser_out, load_done;
  logic [3:0] rate_sel;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk_sys = ~clk_sys;

  scfg_rx #(.SLOW_HALF(SH), .DEF_HALF(DH), .SLOW_BYTES(SB), .RATE_BYTE(RB),
            .TOTAL_BITS(TB)) dut_i (
    .clk_sys(clk_sys), .rst_n(rst_n), .cfg_mode(cfg_mode), .ser_in(ser_in),
    .cfg_clk(cfg_clk), .ser_out(ser_out), .load_done(load_done), .rate_sel(rate_sel));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_sys) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      summary();
    end
  end

  function automatic logic [7:0] byte_of(input int b, input int code);
    if (b == RB) return {4'h9, 4'(code)};
    return 8'(b * 29 + 7 + code * 3);
  endfunction

  function automatic logic bit_of(input int k, input int code);
    logic [7:0] v = byte_of(k / 8, code);
    return v[7 - (k % 8)];
  endfunction

  function automatic int fast_half(input int code);
    return (DH + code) / (code + 1);
  endfunction

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk_sys);
    cfg_mode = m;
    rst_n = 1'b0;
    repeat (2) @(negedge clk_sys);
    // R2: quiet outputs while held in reset
    chk(cfg_clk == 0 && ser_out == 0 && load_done == 0 && rate_sel == 0,
        "R2 reset state", {cfg_clk, ser_out, load_done, rate_sel}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_stream(input int code);
    realtime tr, tf;
    int ph;
    ser_in = bit_of(0, code);
    do_reset(code[0] ? 3'b100 : 3'b000);
    tf = 0.0;
    for (int k = 0; k < NB; k++) begin
      ph = (k >= SB * 8) ? fast_half(code) : SH;
      @(posedge cfg_clk);
      tr = $realtime;
      if (k >= 1)
        chk(int'(tr - tf) == ph * 10, (k >= SB * 8) ? "R5 low phase" : "R3 low phase",
            int'(tr - tf), ph * 10);
      @(negedge clk_sys);
      if (k >= TB)
        chk(rate_sel == 4'(code), "R9 code frozen", rate_sel, code);
      else
        chk(rate_sel == ((k >= RB * 8 + 7) ? 4'(code) : 4'd0), "R4 rate code",
            rate_sel, (k >= RB * 8 + 7) ? code : 0);
      chk(load_done == (k >= TB - 1), "R7 done", load_done, k >= TB - 1);
      chk(ser_out == ((k >= TB) ? bit_of(k, code) : 1'b0), "R8 chain out",
          ser_out, (k >= TB) ? bit_of(k, code) : 0);
      @(negedge cfg_clk);
      tf = $realtime;
      chk(int'(tf - tr) == ph * 10,
          (k == SB * 8 - 1) ? "R6 last slow high" : ((k >= SB * 8) ? "R5 high phase" : "R3 high phase"),
          int'(tf - tr), ph * 10);
      #1 ser_in = bit_of(k + 1, code);
    end
  endtask

  task automatic mode_sweep();
    int tog;
    logic last;
    for (int m = 0; m < 8; m++) begin
      do_reset(3'(m));
      tog = 0;
      last = cfg_clk;
      repeat (4 * SH + 6) begin
        @(negedge clk_sys);
        if (cfg_clk != last) tog++;
        last = cfg_clk;
      end
      // R1: runs only for low mode bits 00, top bit ignored
      chk((tog > 0) == (m[1:0] == 2'b00), "R1 mode enable", tog, (m[1:0] == 0) ? 1 : 0);
    end
    do_reset(3'b000);
    repeat (SH * 3 + 2) @(negedge clk_sys);
    cfg_mode = 3'b010;
    last = cfg_clk;
    tog = 0;
    repeat (3 * SH) begin
      @(negedge clk_sys);
      if (cfg_clk != last) tog++;
    end
    chk(tog == 0, "R1 freeze when disabled", tog, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_mode = 3'b000;
    ser_in = 1'b0;
    mode_sweep();
    for (int c = 0; c < 16; c++) run_stream(c);
    summary();
  end
endmodule